// File: doc/BRIEF.md
# Packed Lane Shift, Rotate and Halfword Shuffle Unit

This unit takes a 64-bit operand and applies one of five operations to it. Four of them shift or rotate: logical right, logical left, arithmetic right and rotate right. Each of these works independently inside 16-bit lanes, inside 32-bit lanes, or on the whole 64-bit word. The fifth operation rearranges the four 16-bit halfwords under the control of an 8-bit selector. Together with the result, the unit produces a 32-bit status word. That word holds a negative flag and a zero flag for every lane of the result, and the lane size decides where each flag sits.

A request is captured in an input register on a clock edge where the valid input is high. The result and status are valid during the next cycle. A new request can be issued on every cycle. The shift amount is 6 bits wide. Amounts at or beyond the lane width saturate in a well-defined way, and rotate amounts wrap around the lane width.

Top module: `psr_unit`

## Requirements
- R1: When `in_valid` is high at a rising edge, `out_valid` is high for the following cycle, and `out_data`/`out_flags` hold the result of that request during that cycle.
- R2: While `out_valid` is low (including during and right after reset, which is synchronous and active high), `out_data` and `out_flags` are all zero.
- R3: Logical right (`in_op`=0) and logical left (`in_op`=1) shift each lane by `in_amt`. Bits shifted past a lane edge are dropped and never enter a neighbouring lane. Lane size `in_lane`: 0 = 16 bits, 1 = 32 bits, 2 or 3 = 64 bits.
- R4: Arithmetic right shift (`in_op`=2) fills each lane from that lane's own top bit.
- R5: Rotate right (`in_op`=3) rotates each lane by `in_amt` modulo the lane width. Bits leaving the bottom of a lane re-enter at the top of the same lane.
- R6: A shift amount of zero returns the operand unchanged for op codes 0 to 3, including rotate. Op codes 5 to 7 always return the operand unchanged.
- R7: For an amount at or above the lane width, logical shifts give a zero lane and arithmetic right shift gives a lane filled with the lane's sign bit.
- R8: Shuffle (`in_op`=4): result halfword k (bits 16k+15..16k) is source halfword number `in_sel[2k+1:2k]`, for k = 0 to 3. `in_lane` and `in_amt` have no effect.
- R9: For lane width W with L = 64/W lanes and spacing S = 32/L, lane i drives its negative flag (the lane's top bit) at `out_flags` bit S*(i+1)-1 and its zero flag at bit S*(i+1)-2. Every other bit of `out_flags` is zero.
- R10: The shuffle always reports its flags in the 16-bit lane positions (bits 8h+7 and 8h+6 for halfword h), whatever `in_lane` is.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Request strobe |
| in_op | input | 3 | Operation code (0 SRL, 1 SLL, 2 SRA, 3 ROR, 4 shuffle) |
| in_lane | input | 2 | Lane size code (0: 16, 1: 32, 2/3: 64 bits) |
| in_data | input | 64 | Operand |
| in_amt | input | 6 | Shift or rotate amount |
| in_sel | input | 8 | Halfword shuffle selector |
| out_valid | output | 1 | Result valid, one cycle after the request |
| out_data | output | 64 | Result |
| out_flags | output | 32 | Per-lane negative and zero flags |

## Verification
For every shift mode and every lane size, each amount from zero up to one below the lane width is applied to random operands. This separates lane-confined shifting from whole-word shifting, and it shows up any edge case where the rotate wraps. Amounts above the lane width are tried for the logical and arithmetic modes, so that saturation can be told apart from modulo behaviour. Operands with set sign bits in each lane show whether arithmetic fill comes from the lane's own top bit. Random and directed shuffle selectors, including the identity and the full reversal, are run under every lane code. These runs check the halfword mapping and confirm that the flags stay in the 16-bit positions. Zero-valued lanes exercise the zero flags.

// File: rtl/psr_pkg.sv
package psr_pkg;

    localparam int DATA_W = 64;
    localparam int AMT_W  = 6;
    localparam int SEL_W  = 8;
    localparam int FLAG_W = 32;
    localparam int HALF_W = 16;
    localparam int NUM_HALF = DATA_W / HALF_W;
    localparam int NUM_SIZES = 3;

    typedef enum logic [2:0] {
        OP_SRL  = 3'd0,
        OP_SLL  = 3'd1,
        OP_SRA  = 3'd2,
        OP_ROR  = 3'd3,
        OP_SHUF = 3'd4
    } op_e;

    typedef enum logic [1:0] {
        LN_16 = 2'd0,
        LN_32 = 2'd1,
        LN_64 = 2'd2,
        LN_64B = 2'd3
    } lane_e;

    typedef struct packed {
        logic              valid;
        op_e               op;
        lane_e             lane;
        logic [DATA_W-1:0] data;
        logic [AMT_W-1:0]  amt;
        logic [SEL_W-1:0]  sel;
    } req_t;

    // index of the shifter bank for a lane code
    function automatic int size_index(lane_e ln);
        case (ln)
            LN_16:   return 0;
            LN_32:   return 1;
            default: return 2;
        endcase
    endfunction

    // union of every flag slot any lane size can use
    function automatic logic [FLAG_W-1:0] flag_slot_mask();
        logic [FLAG_W-1:0] m;
        m = '0;
        for (int h = 0; h < NUM_HALF; h++) begin
            m[(FLAG_W/NUM_HALF)*(h+1)-1] = 1'b1;
            m[(FLAG_W/NUM_HALF)*(h+1)-2] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/lane_shifter.sv
module lane_shifter
    import psr_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int LW = 16
) (
    input  op_e              op,
    input  logic [DW-1:0]    data,
    input  logic [AMT_W-1:0] amt,
    output logic [DW-1:0]    res
);
    localparam int NL = DW / LW;
    localparam int RW = $clog2(LW);
    localparam logic [AMT_W:0] LW_V = (AMT_W+1)'(LW);

    logic [AMT_W:0] amt_ext;
    logic           sat;
    logic [RW-1:0]  rot_amt;
    logic [AMT_W:0] rot_back;

    assign amt_ext  = {1'b0, amt};
    assign sat      = (amt_ext >= LW_V);
    assign rot_amt  = amt[RW-1:0];
    assign rot_back = LW_V - (AMT_W+1)'(rot_amt);

    for (genvar l = 0; l < NL; l++) begin : g_lane
        logic [LW-1:0] x;
        logic [LW-1:0] y;
        assign x = data[l*LW +: LW];

        always_comb begin
            case (op)
                OP_SRL: y = sat ? '0 : (x >> amt);
                OP_SLL: y = sat ? '0 : (x << amt);
                OP_SRA: y = sat ? {LW{x[LW-1]}} : LW'($signed(x) >>> amt);
                OP_ROR: begin
                    if (rot_amt == '0)
                        y = x;
                    else
                        y = (x >> rot_amt) | (x << rot_back);
                end
                default: y = x;
            endcase
        end

        assign res[l*LW +: LW] = y;
    end

endmodule

// File: rtl/halfword_shuffler.sv
module halfword_shuffler
    import psr_pkg::*;
#(
    parameter int DW = DATA_W
) (
    input  logic [DW-1:0]    data,
    input  logic [SEL_W-1:0] sel,
    output logic [DW-1:0]    res
);
    localparam int NH = DW / HALF_W;

    always_comb begin
        res = '0;
        for (int k = 0; k < NH; k++) begin
            res[k*HALF_W +: HALF_W] = data[int'(sel[2*k +: 2])*HALF_W +: HALF_W];
        end
    end

endmodule

// File: rtl/lane_flags.sv
module lane_flags
    import psr_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int FW = FLAG_W
) (
    input  logic [DW-1:0] res,
    input  lane_e         lane,
    output logic [FW-1:0] flags
);
    for (genvar g = 0; g < NUM_SIZES; g++) begin : g_sz
        localparam int LW = HALF_W << g;
        localparam int NL = DW / LW;
        localparam int SP = FW / NL;
        logic [FW-1:0] fv;

        always_comb begin
            fv = '0;
            for (int i = 0; i < NL; i++) begin
                fv[SP*(i+1)-1] = res[i*LW + LW - 1];
                fv[SP*(i+1)-2] = (res[i*LW +: LW] == '0);
            end
        end
    end

    always_comb begin
        case (size_index(lane))
            0:       flags = g_sz[0].fv;
            1:       flags = g_sz[1].fv;
            default: flags = g_sz[2].fv;
        endcase
    end

endmodule

// File: rtl/psr_unit.sv
module psr_unit
    import psr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [2:0]        in_op,
    input  logic [1:0]        in_lane,
    input  logic [DATA_W-1:0] in_data,
    input  logic [AMT_W-1:0]  in_amt,
    input  logic [SEL_W-1:0]  in_sel,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    output logic [FLAG_W-1:0] out_flags
);
    localparam logic [FLAG_W-1:0] SLOT_MASK = flag_slot_mask();

    req_t req_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q <= '0;
        end else begin
            req_q.valid <= in_valid;
            if (in_valid) begin
                req_q.op   <= op_e'(in_op);
                req_q.lane <= lane_e'(in_lane);
                req_q.data <= in_data;
                req_q.amt  <= in_amt;
                req_q.sel  <= in_sel;
            end
        end
    end

    // one shifter bank per lane width
    for (genvar g = 0; g < NUM_SIZES; g++) begin : g_bank
        logic [DATA_W-1:0] res;
        lane_shifter #(.DW(DATA_W), .LW(HALF_W << g)) u_shift (
            .op   (req_q.op),
            .data (req_q.data),
            .amt  (req_q.amt),
            .res  (res)
        );
    end

    logic [DATA_W-1:0] shuf_res;
    halfword_shuffler #(.DW(DATA_W)) u_shuf (
        .data (req_q.data),
        .sel  (req_q.sel),
        .res  (shuf_res)
    );

    logic [DATA_W-1:0] result;
    lane_e             flag_lane;

    always_comb begin
        if (req_q.op == OP_SHUF) begin
            result    = shuf_res;
            flag_lane = LN_16;
        end else begin
            flag_lane = req_q.lane;
            case (size_index(req_q.lane))
                0:       result = g_bank[0].res;
                1:       result = g_bank[1].res;
                default: result = g_bank[2].res;
            endcase
        end
    end

    logic [FLAG_W-1:0] flags;
    lane_flags #(.DW(DATA_W), .FW(FLAG_W)) u_flags (
        .res   (result),
        .lane  (flag_lane),
        .flags (flags)
    );

    assign out_valid = req_q.valid;
    assign out_data  = req_q.valid ? result : '0;
    assign out_flags = req_q.valid ? flags  : '0;

    AST_LATENCY: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid); // R1

    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && out_data == '0 && out_flags == '0)); // R2

    AST_ZERO_AMT: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_amt == '0 && in_op != 3'd4) |=> out_data == $past(in_data)); // R6

    AST_SHUF_IDENT: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_op == 3'd4 && in_sel == 8'hE4) |=> out_data == $past(in_data)); // R8

    AST_FLAG_SLOTS: assert property (@(posedge clk) disable iff (rst)
        (out_flags & ~SLOT_MASK) == '0); // R9

    AST_WORD_FLAGS: assert property (@(posedge clk) disable iff (rst)
        (out_valid && req_q.op != OP_SHUF && size_index(req_q.lane) == 2) |->
        (out_flags[31] == out_data[63] && out_flags[30] == (out_data == '0))); // R9

endmodule

// File: tb/sim_psr_unit.sv
module sim_psr_unit;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [2:0]  in_op = '0;
    logic [1:0]  in_lane = '0;
    logic [63:0] in_data = '0;
    logic [5:0]  in_amt = '0;
    logic [7:0]  in_sel = '0;
    logic        out_valid;
    logic [63:0] out_data;
    logic [31:0] out_flags;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    psr_unit u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_op(in_op),
        .in_lane(in_lane), .in_data(in_data), .in_amt(in_amt),
        .in_sel(in_sel), .out_valid(out_valid), .out_data(out_data),
        .out_flags(out_flags)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic int width_of(logic [1:0] ln);
        return (ln == 2'd0) ? 16 : (ln == 2'd1) ? 32 : 64;
    endfunction

    function automatic logic [63:0] model_res(logic [2:0] op, logic [1:0] ln,
                                              logic [63:0] x, int n, logic [7:0] sel);
        logic [63:0] r, mask, v, e;
        logic signed [63:0] sv;
        int w, rr;
        r = '0;
        if (op == 3'd4) begin
            for (int k = 0; k < 4; k++) r[k*16 +: 16] = x[int'(sel[2*k +: 2])*16 +: 16];
            return r;
        end
        if (op > 3'd4) return x;
        w = width_of(ln);
        mask = (w == 64) ? '1 : ((64'd1 << w) - 64'd1);
        for (int l = 0; l < 64 / w; l++) begin
            v = (x >> (l*w)) & mask;
            case (op)
                3'd0: e = v >> n;
                3'd1: e = (v << n) & mask;
                3'd2: begin
                    sv = ((v >> (w-1)) & 64'd1) != 0 ? (v | ~mask) : v;
                    e  = 64'(sv >>> n) & mask;
                end
                default: begin
                    rr = n % w;
                    e = (rr == 0) ? v : (((v >> rr) | (v << (w - rr))) & mask);
                end
            endcase
            r |= e << (l*w);
        end
        return r;
    endfunction

    function automatic logic [31:0] model_flags(logic [63:0] r, int w);
        logic [31:0] f;
        logic [63:0] mask;
        int nl, sp;
        f = '0;
        nl = 64 / w;
        sp = 32 / nl;
        mask = (w == 64) ? '1 : ((64'd1 << w) - 64'd1);
        for (int i = 0; i < nl; i++) begin
            f[sp*(i+1)-1] = r[i*w + w - 1];
            f[sp*(i+1)-2] = (((r >> (i*w)) & mask) == 64'd0);
        end
        return f;
    endfunction

    task automatic check(string tag, string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic apply(logic [2:0] op, logic [1:0] ln, logic [63:0] x,
                         int n, logic [7:0] sel, string tag);
        logic [63:0] er;
        @(negedge clk);
        in_valid = 1'b1; in_op = op; in_lane = ln; in_data = x;
        in_amt = 6'(n); in_sel = sel;
        @(negedge clk);
        in_valid = 1'b0;
        er = model_res(op, ln, x, n, sel);
        check("R1", "valid", 64'(out_valid), 64'd1);
        check(tag, "data", out_data, er);
        if (op == 3'd4)
            check("R10", "flags", 64'(out_flags), 64'(model_flags(er, 16)));
        else
            check("R9", "flags", 64'(out_flags), 64'(model_flags(er, width_of(ln))));
    endtask

    function automatic logic [63:0] rnd64();
        return {$urandom(), $urandom()};
    endfunction

    initial begin
        for (int c = 0; c < WATCHDOG; c++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        string tag;
        logic [63:0] x;
        void'($urandom(32'd2024));
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R2", "reset valid", 64'(out_valid), 64'd0);
        check("R2", "reset data", out_data, 64'd0);
        check("R2", "reset flags", 64'(out_flags), 64'd0);
        rst = 1'b0;

        // sweep every in-range amount for every shift mode and lane size
        for (int op = 0; op < 4; op++) begin
            for (int ln = 0; ln < 3; ln++) begin
                for (int n = 0; n < width_of(2'(ln)); n++) begin
                    x = rnd64();
                    if (n == 0) tag = "R6";
                    else if (op < 2) tag = "R3";
                    else if (op == 2) tag = "R4";
                    else tag = "R5";
                    apply(3'(op), 2'(ln), x, n, 8'h00, tag);
                end
            end
        end

        // amounts at or above lane width
        for (int op = 0; op < 4; op++) begin
            for (int ln = 0; ln < 2; ln++) begin
                for (int n = width_of(2'(ln)); n < 64; n += 5)
                    apply(3'(op), 2'(ln), rnd64(), n, 8'h00, (op == 3) ? "R5" : "R7");
            end
        end

        // directed corners
        apply(3'd2, 2'd0, 64'h8000_7FFF_8001_0001, 15, 8'h00, "R4");
        apply(3'd2, 2'd1, 64'h8000_0000_7FFF_FFFF, 40, 8'h00, "R7");
        apply(3'd0, 2'd0, 64'hFFFF_FFFF_FFFF_FFFF, 4, 8'h00, "R3");
        apply(3'd1, 2'd1, 64'hFFFF_FFFF_FFFF_FFFF, 8, 8'h00, "R3");
        apply(3'd3, 2'd0, 64'h0001_0002_0004_8001, 1, 8'h00, "R5");
        apply(3'd3, 2'd3, 64'h0000_0000_0000_0001, 1, 8'h00, "R5");
        apply(3'd0, 2'd2, 64'h0000_0000_0000_0000, 0, 8'h00, "R6");
        apply(3'd5, 2'd0, 64'h1234_5678_9ABC_DEF0, 9, 8'hFF, "R6");
        apply(3'd7, 2'd1, 64'h8000_0000_0000_0000, 3, 8'h00, "R6");

        // shuffles, lane code and amount must not matter
        apply(3'd4, 2'd2, 64'h0004_0003_0002_0001, 17, 8'hE4, "R8");
        apply(3'd4, 2'd1, 64'h0004_0003_0002_0001, 3, 8'h1B, "R8");
        apply(3'd4, 2'd0, 64'h8000_0000_1111_2222, 0, 8'h00, "R8");
        for (int i = 0; i < 40; i++)
            apply(3'd4, 2'($urandom_range(3)), rnd64(), int'($urandom_range(63)),
                  8'($urandom()), "R8");

        // mixed random traffic
        for (int i = 0; i < 120; i++)
            apply(3'($urandom_range(4)), 2'($urandom_range(3)), rnd64(),
                  int'($urandom_range(63)), 8'($urandom()), "R3");

        // idle after traffic
        @(negedge clk);
        check("R2", "idle valid", 64'(out_valid), 64'd0);
        check("R2", "idle data", out_data, 64'd0);
        check("R2", "idle flags", 64'(out_flags), 64'd0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule